// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block takes one decoded block-transfer instruction and turns it into a stream of simple micro-operations, one per cycle. The instruction names a set of up to sixteen general registers, a base register, and the addressing mode. The micro-ops go to a downstream execution stage. Each micro-op is an add-immediate, a subtract-immediate, a load or a store, and carries its own register indices, an 8-bit unsigned offset, an offset-sign bit and an end-of-sequence flag.

The first micro-op always copies the base register into a scratch register. Every memory micro-op then addresses through that scratch register, so an early write to the base register cannot move later addresses. The memory micro-ops visit the listed registers from the lowest index upward. In descending modes the first offset is chosen so that the lowest register still lands at the lowest address. An optional last micro-op writes the updated address back to the base register. Both sides use a valid/ready handshake. A new instruction is taken only after the previous stream has fully drained.

Top module: `lsm_seq`

## Requirements
- R1: The first micro-op after an instruction is accepted is an add-immediate (opcode 0) with destination equal to the scratch register index 32, base equal to the instruction's base register, offset 0 and sign bit 0. Every load or store micro-op uses the scratch register index 32 as its base.
- R2: One memory micro-op is emitted for each set bit of the register list, in ascending register order. The opcode is 2 (load) when the load flag is set and 3 (store) otherwise.
- R3: In increment mode the first memory offset is 0, or 4 when pre-indexing is selected. Each following memory micro-op's offset is 4 larger, and the sign bit is 0.
- R4: In decrement mode the first memory offset is 4×N−4, or 4×N when pre-indexing is selected, where N is the number of set list bits. Each following memory micro-op's offset is 4 smaller, and the sign bit is 1 (address = scratch − offset).
- R5: With writeback set, the last micro-op updates the base register, with destination and base both equal to the base register index, offset 4×N and sign bit 0. Its opcode is 0 (add) in increment mode and 1 (subtract) in decrement mode.
- R6: With the user-bank flag set, the register index of each memory micro-op is 16 plus the list bit position. Without the flag it is the bit position itself.
- R7: A sequence is N+1 micro-ops long, or N+2 with writeback. Only its final micro-op carries the last flag, and out_valid falls in the cycle after that micro-op is taken.
- R8: With an empty register list, only the copy micro-op is emitted, and it carries the last flag. With writeback also set, the copy micro-op is followed by a base update with offset 0.
- R9: While out_valid is high and out_ready is low, every micro-op output holds its value.
- R10: After reset, out_valid is 0 and in_ready is 1. in_ready is 0 for as long as a sequence is being emitted, and it returns to 1 in the cycle after the last micro-op is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Sequencer idle, instruction taken when in_valid is high |
| in_reglist | input | 16 | Register list, bit i selects register i |
| in_base | input | 4 | Base register index |
| in_up | input | 1 | 1 = increment addresses, 0 = decrement |
| in_pre | input | 1 | 1 = pre-index (start offset + 4) |
| in_load | input | 1 | 1 = load, 0 = store |
| in_wback | input | 1 | 1 = append a base update micro-op |
| in_user | input | 1 | 1 = map transferred registers to the user bank |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_op | output | 2 | 0 add-imm, 1 sub-imm, 2 load, 3 store |
| out_rd | output | 6 | Destination or data register index |
| out_rb | output | 6 | Base register index of the micro-op |
| out_imm | output | 8 | Unsigned offset or immediate |
| out_neg | output | 1 | 1 = address is base minus offset |
| out_last | output | 1 | Final micro-op of the sequence |

## Verification
The assertions assume that the downstream side never retracts readiness in a way that matters to the sequencer, so a micro-op is taken on any edge where out_valid and out_ready are both high. They also assume that the instruction fields are only sampled in the cycle in which in_valid and in_ready are both high. The stimulus drives every instruction field together with in_valid for exactly that accepting cycle. It then drops in_valid until the stream has drained, and it varies out_ready with a fixed stall pattern so that the hold behaviour is exercised without ever violating the handshake.

// File: rtl/lsm_pkg.sv
// Shared types for the block-transfer micro-op sequencer.
// Assumes a two-bit opcode field that the downstream stage decodes.
package lsm_pkg;

    typedef enum logic [1:0] {
        UOP_ADDI = 2'd0,
        UOP_SUBI = 2'd1,
        UOP_LDR  = 2'd2,
        UOP_STR  = 2'd3
    } uop_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COPY = 2'd1,
        PH_MEM  = 2'd2,
        PH_WB   = 2'd3
    } seq_phase_e;

    typedef struct packed {
        logic up;
        logic pre;
        logic load;
        logic wback;
        logic user;
    } xfer_mode_t;

endpackage

// File: rtl/lsm_popcount.sv
// Counts the set bits of a register list.
// Purely combinational; CNT_W must hold the value W.
module lsm_popcount #(
    parameter int W     = 16,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] count
);
    // Sum the bits of the list one by one.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
// Finds the lowest set bit of a vector: its index, a one-hot mask of it,
// and whether it is the only bit set. Purely combinational.
module lsm_lowbit #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     onehot,
    output logic             found,
    output logic             single
);
    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Isolate the lowest bit and test whether any other bit remains.
    always_comb begin
        onehot = vec & (~vec + W'(1));
        found  = |vec;
        single = found && ((vec & (vec - W'(1))) == '0);
    end
endmodule

// File: rtl/lsm_seq.sv
// Block-transfer micro-op sequencer.
// Accepts one instruction when idle and emits a copy micro-op, one memory
// micro-op per listed register (ascending), and an optional base update.
// Assumes the instruction fields are valid only in the accepting cycle and
// that a micro-op is consumed on any edge with out_valid and out_ready high.
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int LIST_W    = 16,
    parameter int REG_W     = 6,
    parameter int OFF_W     = 8,
    parameter int USER_BASE = 16,
    parameter int TMP_REG   = 32,
    parameter int STEP      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_reglist,
    input  logic [3:0]       in_base,
    input  logic             in_up,
    input  logic             in_pre,
    input  logic             in_load,
    input  logic             in_wback,
    input  logic             in_user,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_op,
    output logic [REG_W-1:0] out_rd,
    output logic [REG_W-1:0] out_rb,
    output logic [OFF_W-1:0] out_imm,
    output logic             out_neg,
    output logic             out_last
);
    localparam int IDX_W = $clog2(LIST_W);
    localparam int CNT_W = $clog2(LIST_W + 1);

    seq_phase_e         phase_q;
    xfer_mode_t         mode_q;
    logic [LIST_W-1:0]  list_q;
    logic [IDX_W-1:0]   base_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [OFF_W-1:0]   off_q;

    logic [CNT_W-1:0]   in_cnt;
    logic [OFF_W-1:0]   start_off;
    logic [OFF_W-1:0]   cnt_bytes;
    logic [IDX_W-1:0]   low_idx;
    logic [LIST_W-1:0]  low_mask;
    logic               low_found;
    logic               low_single;
    logic               fire;
    logic               accept;

    lsm_popcount #(.W(LIST_W), .CNT_W(CNT_W)) u_count (
        .vec   (in_reglist),
        .count (in_cnt)
    );

    lsm_lowbit #(.W(LIST_W), .IDX_W(IDX_W)) u_low (
        .vec    (list_q),
        .idx    (low_idx),
        .onehot (low_mask),
        .found  (low_found),
        .single (low_single)
    );

    // Handshake strobes on both sides.
    always_comb begin
        in_ready  = (phase_q == PH_IDLE);
        out_valid = (phase_q != PH_IDLE);
        accept    = in_valid && in_ready;
        fire      = out_valid && out_ready;
    end

    // First memory offset: 4N-4 when descending, plus 4 for pre-indexing.
    always_comb begin
        start_off = in_up ? '0 : ((OFF_W'(in_cnt) * OFF_W'(STEP)) - OFF_W'(STEP));
        if (in_pre) start_off = start_off + OFF_W'(STEP);
        cnt_bytes = OFF_W'(cnt_q) * OFF_W'(STEP);
    end

    // Phase sequencing and latched instruction state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mode_q  <= '0;
            list_q  <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            off_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_COPY;
                        mode_q  <= '{up: in_up, pre: in_pre, load: in_load,
                                     wback: in_wback, user: in_user};
                        list_q  <= in_reglist;
                        base_q  <= in_base;
                        cnt_q   <= in_cnt;
                        off_q   <= start_off;
                    end
                end
                PH_COPY: begin
                    if (fire) begin
                        if (cnt_q != '0)       phase_q <= PH_MEM;
                        else if (mode_q.wback) phase_q <= PH_WB;
                        else                   phase_q <= PH_IDLE;
                    end
                end
                PH_MEM: begin
                    if (fire) begin
                        list_q <= list_q & ~low_mask;
                        off_q  <= mode_q.up ? off_q + OFF_W'(STEP) : off_q - OFF_W'(STEP);
                        if (low_single) phase_q <= mode_q.wback ? PH_WB : PH_IDLE;
                    end
                end
                default: begin
                    if (fire) phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Format the micro-op for the current phase.
    always_comb begin
        out_op   = UOP_ADDI;
        out_rd   = REG_W'(TMP_REG);
        out_rb   = REG_W'(base_q);
        out_imm  = '0;
        out_neg  = 1'b0;
        out_last = 1'b0;
        case (phase_q)
            PH_COPY: begin
                out_last = (cnt_q == '0) && !mode_q.wback;
            end
            PH_MEM: begin
                out_op   = mode_q.load ? UOP_LDR : UOP_STR;
                out_rd   = mode_q.user ? REG_W'(USER_BASE) + REG_W'(low_idx) : REG_W'(low_idx);
                out_rb   = REG_W'(TMP_REG);
                out_imm  = off_q;
                out_neg  = !mode_q.up;
                out_last = low_single && !mode_q.wback;
            end
            PH_WB: begin
                out_op   = mode_q.up ? UOP_ADDI : UOP_SUBI;
                out_rd   = REG_W'(base_q);
                out_imm  = cnt_bytes;
                out_last = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    // R1: an accepted instruction starts with the copy into the scratch register.
    a_r1_copy_first: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_valid && out_op == UOP_ADDI && out_rd == REG_W'(TMP_REG)
                    && out_imm == '0));

    // R1: memory micro-ops address through the scratch register.
    a_r1_mem_via_tmp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op[1]) |-> (out_rb == REG_W'(TMP_REG)));

    // R2: consecutive memory micro-ops visit strictly ascending registers.
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_op[1] && !out_last) |=>
            (!out_op[1] || (out_rd[IDX_W-1:0] > $past(out_rd[IDX_W-1:0]))));

    // R7: the last micro-op ends the stream; any other keeps it going.
    a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> !out_valid);
    a_r7_more_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !out_last) |=> out_valid);

    // R9: a stalled micro-op holds all its fields.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd)
            && $stable(out_rb) && $stable(out_imm) && $stable(out_neg) && $stable(out_last)));

    // R10: no instruction is taken while a stream is being emitted.
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/lsm_seq_bench.sv
`timescale 1ns/1ps
module lsm_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_reglist = '0;
    logic [3:0]  in_base = '0;
    logic        in_up = 1'b0, in_pre = 1'b0, in_load = 1'b0;
    logic        in_wback = 1'b0, in_user = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_op;
    logic [5:0]  out_rd, out_rb;
    logic [7:0]  out_imm;
    logic        out_neg, out_last;

    int errors = 0;
    int checks = 0;

    int e_op[0:17], e_rd[0:17], e_rb[0:17], e_imm[0:17], e_neg[0:17], e_last[0:17];
    string e_req[0:17];
    string e_rdreq[0:17];
    int e_len;

    always #4 clk = ~clk;

    lsm_seq u_lsm_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_reglist(in_reglist), .in_base(in_base), .in_up(in_up), .in_pre(in_pre),
        .in_load(in_load), .in_wback(in_wback), .in_user(in_user),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_rd(out_rd),
        .out_rb(out_rb), .out_imm(out_imm), .out_neg(out_neg), .out_last(out_last)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Build the expected stream from the requirements.
    task automatic build(input logic [15:0] list, input int base, input bit up, input bit pre,
                         input bit load, input bit wb, input bit user);
        int n = 0;
        int off;
        int k;
        for (int r = 0; r < 16; r++) if (list[r]) n++;
        off = up ? 0 : 4 * n - 4;
        if (pre) off += 4;
        e_op[0] = 0; e_rd[0] = 32; e_rb[0] = base; e_imm[0] = 0; e_neg[0] = 0;
        e_req[0] = (n == 0) ? "R8" : "R1"; e_rdreq[0] = e_req[0];
        k = 1;
        for (int r = 0; r < 16; r++) begin
            if (list[r]) begin
                e_op[k] = load ? 2 : 3;
                e_rd[k] = user ? 16 + r : r;
                e_rb[k] = 32;
                e_imm[k] = off;
                e_neg[k] = up ? 0 : 1;
                e_req[k] = up ? "R3" : "R4";
                e_rdreq[k] = user ? "R6" : "R2";
                off = up ? off + 4 : off - 4;
                k++;
            end
        end
        if (wb) begin
            e_op[k] = up ? 0 : 1; e_rd[k] = base; e_rb[k] = base;
            e_imm[k] = 4 * n; e_neg[k] = 0;
            e_req[k] = (n == 0) ? "R8" : "R5"; e_rdreq[k] = e_req[k];
            k++;
        end
        e_len = k;
        for (int i = 0; i < k; i++) e_last[i] = (i == k - 1) ? 1 : 0;
    endtask

    // Send one instruction, collect its stream and compare it.
    task automatic run_seq(input logic [15:0] list, input int base, input bit up, input bit pre,
                           input bit load, input bit wb, input bit user, input bit stall);
        int k = 0;
        int guard = 0;
        int cyc = 0;
        bit held = 0;
        int h_op = 0, h_rd = 0, h_imm = 0, h_last = 0;
        build(list, base, up, pre, load, wb, user);
        @(negedge clk);
        in_reglist = list; in_base = 4'(base); in_up = up; in_pre = pre;
        in_load = load; in_wback = wb; in_user = user; in_valid = 1'b1;
        out_ready = 1'b0;
        #1;
        chk("R10", "in_ready when idle", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0; in_reglist = 16'hA5A5; in_base = 4'hF;
        while (k < e_len && guard < 200) begin
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
            guard++;
            #1;
            if (!out_valid || in_ready) begin
                chk("R10", "valid and not ready while busy", {out_valid, in_ready}, 2);
            end
            if (held) begin
                chk("R9", "op held", out_op, h_op);
                chk("R9", "rd held", out_rd, h_rd);
                chk("R9", "imm held", out_imm, h_imm);
                chk("R9", "last held", out_last, h_last);
            end
            if (out_ready && out_valid) begin
                chk(e_rdreq[k], "op", out_op, e_op[k]);
                chk(e_rdreq[k], "rd", out_rd, e_rd[k]);
                chk(e_req[k], "rb", out_rb, e_rb[k]);
                chk(e_req[k], "imm", out_imm, e_imm[k]);
                chk(e_req[k], "neg", out_neg, e_neg[k]);
                chk("R7", "last flag", out_last, e_last[k]);
                k++;
                held = 0;
            end else begin
                held = out_valid;
                h_op = out_op; h_rd = out_rd; h_imm = out_imm; h_last = out_last;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        chk("R7", "stream length", k, e_len);
        chk("R7", "out_valid after last", out_valid, 0);
        chk("R10", "in_ready after last", in_ready, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "out_valid at reset", out_valid, 0);
        chk("R10", "in_ready at reset", in_ready, 1);
    endtask

    task automatic t_inc_post_store();   // R2 R3
        run_seq(16'h0013, 3, 1, 0, 0, 0, 0, 0);
    endtask
    task automatic t_inc_pre_load_wb();  // R3 R5
        run_seq(16'h8421, 13, 1, 1, 1, 1, 0, 0);
    endtask
    task automatic t_dec_post_wb();      // R4 R5
        run_seq(16'h00F0, 2, 0, 0, 0, 1, 0, 1);
    endtask
    task automatic t_dec_pre_user();     // R4 R6
        run_seq(16'h0306, 5, 0, 1, 1, 0, 1, 0);
    endtask
    task automatic t_full_stall();       // R9 R4 R5
        run_seq(16'hFFFF, 0, 0, 1, 1, 1, 0, 1);
    endtask
    task automatic t_empty_nowb();       // R8
        run_seq(16'h0000, 7, 1, 0, 0, 0, 0, 0);
    endtask
    task automatic t_empty_wb();         // R8
        run_seq(16'h0000, 9, 1, 1, 1, 1, 0, 1);
    endtask
    task automatic t_single_user_stall(); // R6 R9
        run_seq(16'h4000, 1, 1, 0, 0, 1, 1, 1);
    endtask

    initial begin
        t_reset();
        t_inc_post_store();
        t_inc_pre_load_wb();
        t_dec_post_wb();
        t_dec_pre_user();
        t_full_stall();
        t_empty_nowb();
        t_empty_wb();
        t_single_user_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule